// File: doc/BRIEF.md
# Legacy Real-Mode Memory Region Decoder

This block sits between an emulated real-mode processor core and the memories behind it. Each request carries a physical address, a read or write flag and a byte, word or dword size. The block sends the request to one of three backing targets: main RAM, the option-ROM image or the legacy video window. Each forwarded request carries an offset inside the chosen target. Reads of a small identification area at the top of the 1 MB space are answered from internal constants, and those bytes come back little-endian.

The upper end of the ROM window is held in a register that is loaded through a configuration input. Addresses between that limit and 0xD0000 are treated as suspect and go to RAM offset 0. A video-emulation input makes the video window read as zero and discard writes. An address at or past the configured RAM size that matches no other region raises a sticky halt flag. That access is sent to RAM offset 0.

Every request gets exactly one registered response one cycle later. The response states the target and offset, or else carries the locally produced read data.

Top module: `legacy_addr_decoder`

## Requirements
- R1: With the video-emulation input low, an address from 0xC0000 up to and including the ROM limit is forwarded with tgt_sel_o = 1 (ROM) and offset address − 0xC0000.
- R2: An address above the ROM limit and below 0xD0000 is forwarded with tgt_sel_o = 0 (RAM) and offset 0, and the halt flag does not rise.
- R3: With the video-emulation input low, an address from 0xA0000 to 0xBFFFF that R2 does not claim is forwarded with tgt_sel_o = 2 (video) and offset address − 0xA0000.
- R4: With the video-emulation input high, any access in 0xA0000 to 0xBFFFF of any size is not forwarded. Its response has tgt_req_o = 0, tgt_sel_o = 3 (none) and local_rdata_o = 0.
- R5: Reads at 0xFFFF5 to 0xFFFFC return the eight ASCII characters of the date string, first character at the lowest address. A read at 0xFFFFD returns 0x00. Writes anywhere in 0xFFFF5 to 0xFFFFF are not forwarded: tgt_req_o = 0 and tgt_sel_o = 3.
- R6: A read at 0xFFFFE returns the model byte 0xFC, and a read at 0xFFFFF returns the submodel byte 0x00.
- R7: Identification reads are little-endian. For size 0 (byte), 1 (word) or 2 (dword), byte lane i of local_rdata_o holds the identification byte of address + i. A lane whose address lies outside 0xFFFF5 to 0xFFFFF holds 0, and so does any lane beyond the access size.
- R8: An address at or above RAM_SIZE that no earlier rule claims is forwarded to RAM offset 0 and raises halt_o with that response. halt_o then stays high until reset.
- R9: Any other address is forwarded to RAM (tgt_sel_o = 0) at an offset equal to the address.
- R10: The ROM limit resets to ROM_LIMIT_RST. A cycle with cfg_we_i high loads cfg_limit_i, and the new limit governs requests from the next cycle onward. A request in the same cycle still uses the old limit.
- R11: The rules are applied in this order: video suppression (R4), ROM window, ROM hole, video window, identification area, RAM overflow, plain RAM. So with a limit below 0xA0000, the hole claims the video window and maps it to RAM offset 0.
- R12: Each request produces resp_valid_o exactly one cycle later, and no response appears without a request. The response echoes the request's write flag, size and write data. For forwarded requests, local_rdata_o is 0. After reset, resp_valid_o and halt_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load the ROM limit register |
| cfg_limit_i | input | AW | New ROM window upper limit (inclusive) |
| vga_emu_i | input | 1 | Suppress video-window accesses |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | 0 byte, 1 word, 2 or 3 dword |
| req_addr_i | input | AW | Emulated physical address |
| req_wdata_i | input | 32 | Write data, little-endian |
| resp_valid_o | output | 1 | Response for the request one cycle earlier |
| tgt_req_o | output | 1 | Request is forwarded to a backing target |
| tgt_sel_o | output | 2 | 0 RAM, 1 ROM, 2 video, 3 none |
| tgt_write_o | output | 1 | Echoed write flag |
| tgt_size_o | output | 2 | Echoed size |
| tgt_offset_o | output | AW | Offset inside the selected target |
| tgt_wdata_o | output | 32 | Echoed write data |
| local_rdata_o | output | 32 | Data for locally answered reads |
| halt_o | output | 1 | Sticky out-of-range flag |

## Verification
The bench builds the block with AW = 20 and RAM_SIZE = 0x60000, which opens an overflow band from 0x60000 to 0x9FFFF below the video window. Addresses such as 0xD0000 above the ROM hole also overflow, so the halt path and its stickiness can be reached. ROM_LIMIT_RST = 0xC7FFF leaves a hole from 0xC8000 to 0xCFFFF after reset. Later limit loads move the window, close the hole, and drop the limit below 0xA0000 so that the hole takes priority over the video window. The default date string sits in the identification area, so misaligned word and dword reads there cross the model byte, the submodel byte and the top of the address space.

// File: rtl/legacy_dec_pkg.sv
package legacy_dec_pkg;

  typedef enum logic [1:0] {
    TGT_RAM  = 2'd0,
    TGT_ROM  = 2'd1,
    TGT_VID  = 2'd2,
    TGT_NONE = 2'd3
  } tgt_e;

  typedef enum logic [2:0] {
    RG_VSUP  = 3'd0,
    RG_ROM   = 3'd1,
    RG_HOLE  = 3'd2,
    RG_VID   = 3'd3,
    RG_IDENT = 3'd4,
    RG_OVF   = 3'd5,
    RG_RAM   = 3'd6
  } region_e;

  localparam int unsigned LANES = 4;

  localparam logic [31:0] VID_LO_C   = 32'h000A_0000;
  localparam logic [31:0] VID_HI_C   = 32'h000B_FFFF;
  localparam logic [31:0] ROM_LO_C   = 32'h000C_0000;
  localparam logic [31:0] HOLE_END_C = 32'h000D_0000;
  localparam logic [31:0] ID_LO_C    = 32'h000F_FFF5;
  localparam logic [31:0] ID_HI_C    = 32'h000F_FFFF;

endpackage

// File: rtl/rom_limit_reg.sv
module rom_limit_reg #(
  parameter int unsigned AW = 20,
  parameter logic [AW-1:0] RST_VAL = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] d_i,
  output logic [AW-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL;
    else if (we_i) q_o <= d_i;
  end

endmodule

// File: rtl/region_classify.sv
module region_classify
  import legacy_dec_pkg::*;
#(
  parameter int unsigned AW       = 20,
  parameter int unsigned RAM_SIZE = 32'h0008_0000
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] limit_i,
  input  logic          vga_emu_i,
  output region_e       region_o,
  output logic [AW-1:0] offset_o
);

  localparam logic [AW-1:0] VID_LO   = AW'(VID_LO_C);
  localparam logic [AW-1:0] VID_HI   = AW'(VID_HI_C);
  localparam logic [AW-1:0] ROM_LO   = AW'(ROM_LO_C);
  localparam logic [AW-1:0] HOLE_END = AW'(HOLE_END_C);
  localparam logic [AW:0]   ID_LO    = (AW+1)'(ID_LO_C);
  localparam logic [AW:0]   ID_HI    = (AW+1)'(ID_HI_C);
  localparam logic [AW:0]   RAM_TOP  = (AW+1)'(RAM_SIZE);

  logic [AW:0] addr_x;
  logic in_vid, in_rom, in_hole, in_id, in_ovf;

  assign addr_x  = {1'b0, addr_i};
  assign in_vid  = (addr_i >= VID_LO) && (addr_i <= VID_HI);
  assign in_rom  = (addr_i >= ROM_LO) && (addr_i <= limit_i);
  assign in_hole = (addr_i > limit_i) && (addr_i < HOLE_END);
  assign in_id   = (addr_x >= ID_LO) && (addr_x <= ID_HI);
  assign in_ovf  = (addr_x >= RAM_TOP);

  always_comb begin
    region_o = RG_RAM;
    offset_o = addr_i;
    if (vga_emu_i && in_vid) begin
      region_o = RG_VSUP;
      offset_o = '0;
    end else if (in_rom) begin
      region_o = RG_ROM;
      offset_o = addr_i - ROM_LO;
    end else if (in_hole) begin
      region_o = RG_HOLE;
      offset_o = '0;
    end else if (in_vid) begin
      region_o = RG_VID;
      offset_o = addr_i - VID_LO;
    end else if (in_id) begin
      region_o = RG_IDENT;
      offset_o = '0;
    end else if (in_ovf) begin
      region_o = RG_OVF;
      offset_o = '0;
    end
  end

endmodule

// File: rtl/ident_lanes.sv
module ident_lanes
  import legacy_dec_pkg::*;
#(
  parameter int unsigned AW       = 20,
  parameter logic [63:0] DATE_STR = "06/30/98",
  parameter logic [7:0]  MODEL_ID = 8'hFC,
  parameter logic [7:0]  SUB_ID   = 8'h00
) (
  input  logic [AW-1:0] base_i,
  input  logic [1:0]    size_i,
  output logic [31:0]   rdata_o
);

  localparam logic [AW:0] ID_LO = (AW+1)'(ID_LO_C);
  localparam logic [AW:0] ID_HI = (AW+1)'(ID_HI_C);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [AW:0] a;
    logic [AW:0] rel;
    logic [7:0]  b;
    logic        en;

    assign a   = {1'b0, base_i} + (AW+1)'(l);
    assign rel = a - ID_LO;

    if (l == 0) begin : g_en0
      assign en = 1'b1;
    end else if (l == 1) begin : g_en1
      assign en = |size_i;
    end else begin : g_enx
      assign en = size_i[1];
    end

    always_comb begin
      b = 8'h00;
      if ((a >= ID_LO) && (a <= ID_HI)) begin
        if (a == ID_HI)            b = SUB_ID;
        else if (a == ID_HI - 1'b1) b = MODEL_ID;
        else if (rel < 8)          b = DATE_STR[{~rel[2:0], 3'b000} +: 8];
      end
    end

    assign rdata_o[8*l +: 8] = en ? b : 8'h00;
  end

endmodule

// File: rtl/legacy_addr_decoder.sv
module legacy_addr_decoder
  import legacy_dec_pkg::*;
#(
  parameter int unsigned AW            = 20,
  parameter int unsigned RAM_SIZE      = 32'h0008_0000,
  parameter logic [AW-1:0] ROM_LIMIT_RST = AW'(32'h000C_7FFF),
  parameter logic [63:0] DATE_STR      = "06/30/98",
  parameter logic [7:0]  MODEL_ID      = 8'hFC,
  parameter logic [7:0]  SUB_ID        = 8'h00
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [AW-1:0] cfg_limit_i,
  input  logic          vga_emu_i,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [1:0]    req_size_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [31:0]   req_wdata_i,
  output logic          resp_valid_o,
  output logic          tgt_req_o,
  output logic [1:0]    tgt_sel_o,
  output logic          tgt_write_o,
  output logic [1:0]    tgt_size_o,
  output logic [AW-1:0] tgt_offset_o,
  output logic [31:0]   tgt_wdata_o,
  output logic [31:0]   local_rdata_o,
  output logic          halt_o
);

  logic [AW-1:0] limit_q;
  region_e       region;
  logic [AW-1:0] offset;
  logic [31:0]   id_rdata;
  tgt_e          sel_d;
  logic          fwd_d;
  logic [31:0]   rdata_d;

  rom_limit_reg #(
    .AW      (AW),
    .RST_VAL (ROM_LIMIT_RST)
  ) i_limit (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .d_i    (cfg_limit_i),
    .q_o    (limit_q)
  );

  region_classify #(
    .AW       (AW),
    .RAM_SIZE (RAM_SIZE)
  ) i_classify (
    .addr_i    (req_addr_i),
    .limit_i   (limit_q),
    .vga_emu_i (vga_emu_i),
    .region_o  (region),
    .offset_o  (offset)
  );

  ident_lanes #(
    .AW       (AW),
    .DATE_STR (DATE_STR),
    .MODEL_ID (MODEL_ID),
    .SUB_ID   (SUB_ID)
  ) i_ident (
    .base_i  (req_addr_i),
    .size_i  (req_size_i),
    .rdata_o (id_rdata)
  );

  always_comb begin
    sel_d   = TGT_RAM;
    fwd_d   = 1'b1;
    rdata_d = '0;
    unique case (region)
      RG_VSUP: begin
        sel_d = TGT_NONE;
        fwd_d = 1'b0;
      end
      RG_ROM:  sel_d = TGT_ROM;
      RG_VID:  sel_d = TGT_VID;
      RG_IDENT: begin
        sel_d = TGT_NONE;
        fwd_d = 1'b0;
        if (!req_write_i) rdata_d = id_rdata;
      end
      default: sel_d = TGT_RAM;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o  <= 1'b0;
      tgt_req_o     <= 1'b0;
      tgt_sel_o     <= TGT_NONE;
      tgt_write_o   <= 1'b0;
      tgt_size_o    <= '0;
      tgt_offset_o  <= '0;
      tgt_wdata_o   <= '0;
      local_rdata_o <= '0;
      halt_o        <= 1'b0;
    end else begin
      resp_valid_o <= req_valid_i;
      tgt_req_o    <= req_valid_i & fwd_d;
      if (req_valid_i) begin
        tgt_sel_o     <= sel_d;
        tgt_write_o   <= req_write_i;
        tgt_size_o    <= req_size_i;
        tgt_offset_o  <= offset;
        tgt_wdata_o   <= req_wdata_i;
        local_rdata_o <= rdata_d;
        if (region == RG_OVF) halt_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/legacy_addr_decoder_chk.sv
module legacy_addr_decoder_chk #(
  parameter int unsigned AW       = 20,
  parameter int unsigned RAM_SIZE = 32'h0008_0000
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_we_i,
  input logic [AW-1:0] cfg_limit_i,
  input logic          vga_emu_i,
  input logic          req_valid_i,
  input logic          req_write_i,
  input logic [1:0]    req_size_i,
  input logic [AW-1:0] req_addr_i,
  input logic [31:0]   req_wdata_i,
  input logic          resp_valid_o,
  input logic          tgt_req_o,
  input logic [1:0]    tgt_sel_o,
  input logic          tgt_write_o,
  input logic [1:0]    tgt_size_o,
  input logic [AW-1:0] tgt_offset_o,
  input logic [31:0]   tgt_wdata_o,
  input logic [31:0]   local_rdata_o,
  input logic          halt_o
);

  logic in_vid, in_id;
  assign in_vid = ({1'b0, req_addr_i} >= (AW+1)'(32'hA0000)) &&
                  ({1'b0, req_addr_i} <= (AW+1)'(32'hBFFFF));
  assign in_id  = ({1'b0, req_addr_i} >= (AW+1)'(32'hFFFF5)) &&
                  ({1'b0, req_addr_i} <= (AW+1)'(32'hFFFFF));

  assert_resp_timing_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> resp_valid_o);

  assert_no_spurious_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !resp_valid_o);

  assert_echo_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (tgt_write_o == $past(req_write_i)) &&
                    (tgt_size_o == $past(req_size_i)) &&
                    (tgt_wdata_o == $past(req_wdata_i)));

  assert_halt_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);

  assert_video_suppress_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && vga_emu_i && in_vid) |=> (!tgt_req_o && local_rdata_o == 32'h0));

  assert_ident_local_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && in_id) |=> (!tgt_req_o && tgt_sel_o == 2'd3));

  assert_ram_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && tgt_req_o && tgt_sel_o == 2'd0) |->
      ({1'b0, tgt_offset_o} < (AW+1)'(RAM_SIZE)));

  assert_rom_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && tgt_sel_o == 2'd1) |-> ({1'b0, tgt_offset_o} < (AW+1)'(32'h10000)));

  assert_vid_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && tgt_sel_o == 2'd2) |-> ({1'b0, tgt_offset_o} < (AW+1)'(32'h20000)));

  assert_fwd_rdata_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && tgt_req_o) |-> (local_rdata_o == 32'h0));

endmodule

bind legacy_addr_decoder legacy_addr_decoder_chk #(
  .AW       (AW),
  .RAM_SIZE (RAM_SIZE)
) i_chk (.*);

// File: tb/test_legacy_addr_decoder.sv
`timescale 1ns/1ps
module test_legacy_addr_decoder;

  localparam int unsigned AW       = 20;
  localparam int unsigned RAM_SIZE = 32'h0006_0000;
  localparam logic [19:0] LIM_RST  = 20'hC7FFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [19:0] cfg_limit = '0;
  logic vga_emu = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [1:0] req_size = '0;
  logic [19:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic resp_valid, tgt_req, tgt_write, halt;
  logic [1:0] tgt_sel, tgt_size;
  logic [19:0] tgt_offset;
  logic [31:0] tgt_wdata, local_rdata;

  always #2 clk = ~clk;

  legacy_addr_decoder #(
    .AW            (AW),
    .RAM_SIZE      (RAM_SIZE),
    .ROM_LIMIT_RST (LIM_RST)
  ) i_legacy_addr_decoder (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .cfg_we_i      (cfg_we),
    .cfg_limit_i   (cfg_limit),
    .vga_emu_i     (vga_emu),
    .req_valid_i   (req_valid),
    .req_write_i   (req_write),
    .req_size_i    (req_size),
    .req_addr_i    (req_addr),
    .req_wdata_i   (req_wdata),
    .resp_valid_o  (resp_valid),
    .tgt_req_o     (tgt_req),
    .tgt_sel_o     (tgt_sel),
    .tgt_write_o   (tgt_write),
    .tgt_size_o    (tgt_size),
    .tgt_offset_o  (tgt_offset),
    .tgt_wdata_o   (tgt_wdata),
    .local_rdata_o (local_rdata),
    .halt_o        (halt)
  );

  typedef struct {
    logic        fwd;
    logic [1:0]  sel;
    logic        wr;
    logic [1:0]  sz;
    logic [19:0] off;
    logic [31:0] wd;
    logic [31:0] rd;
    logic        hlt;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  logic [19:0] m_limit = LIM_RST;
  bit m_emu = 0;
  bit m_halt = 0;
  string date_s = "06/30/98";

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] id_byte(int unsigned a);
    if (a >= 32'hFFFF5 && a <= 32'hFFFFC) return date_s[a - 32'hFFFF5];
    if (a == 32'hFFFFE) return 8'hFC;
    return 8'h00;
  endfunction

  function automatic exp_t model(bit wr, logic [1:0] sz, logic [19:0] a, logic [31:0] wd, string tag);
    exp_t e;
    bit vid;
    int unsigned n;
    e.wr = wr; e.sz = sz; e.wd = wd; e.rd = '0; e.fwd = 1; e.tag = tag;
    vid = (a >= 20'hA0000 && a <= 20'hBFFFF);
    if (m_emu && vid) begin e.fwd = 0; e.sel = 3; e.off = 0; end
    else if (a >= 20'hC0000 && a <= m_limit) begin e.sel = 1; e.off = a - 20'hC0000; end
    else if (a > m_limit && a < 20'hD0000) begin e.sel = 0; e.off = 0; end
    else if (vid) begin e.sel = 2; e.off = a - 20'hA0000; end
    else if (a >= 20'hFFFF5) begin
      e.fwd = 0; e.sel = 3; e.off = 0;
      if (!wr) begin
        n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        for (int i = 0; i < 4; i++)
          if (i < n) e.rd[8*i +: 8] = id_byte(int'(a) + i);
      end
    end
    else if (a >= RAM_SIZE) begin e.sel = 0; e.off = 0; m_halt = 1; end
    else begin e.sel = 0; e.off = a; end
    e.hlt = m_halt;
    return e;
  endfunction

  task automatic send(bit wr, logic [1:0] sz, logic [19:0] a, logic [31:0] wd, string tag);
    @(negedge clk);
    sb_q.push_back(model(wr, sz, a, wd, tag));
    cfg_we = 0;
    req_valid = 1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
  endtask

  task automatic send_ld(logic [19:0] lim, bit wr, logic [1:0] sz, logic [19:0] a,
                         logic [31:0] wd, string tag);
    @(negedge clk);
    sb_q.push_back(model(wr, sz, a, wd, tag));
    m_limit = lim;
    cfg_we = 1; cfg_limit = lim;
    req_valid = 1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
  endtask

  task automatic load_limit(logic [19:0] lim);
    @(negedge clk);
    req_valid = 0; cfg_we = 1; cfg_limit = lim; m_limit = lim;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic set_emu(bit v);
    @(negedge clk);
    req_valid = 0; cfg_we = 0; vga_emu = v; m_emu = v;
  endtask

  task automatic drain();
    @(negedge clk);
    req_valid = 0; cfg_we = 0;
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (sb_q.size() == 0) begin
        check("R12 unexpected response", 32'(resp_valid), 32'h0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.tag, " fwd"},   32'(tgt_req),   32'(e.fwd));
        check({e.tag, " sel"},   32'(tgt_sel),   32'(e.sel));
        check({e.tag, " off"},   32'(tgt_offset), 32'(e.off));
        check({e.tag, " rdata"}, local_rdata,    e.rd);
        check({e.tag, " halt"},  32'(halt),      32'(e.hlt));
        check({e.tag, " R12 echo"}, {tgt_wdata[27:0], tgt_write, 1'b0, tgt_size},
              {e.wd[27:0], e.wr, 1'b0, e.sz});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 reset resp_valid", 32'(resp_valid), 32'h0);
    check("R8 reset halt", 32'(halt), 32'h0);
    rst_n = 1;

    send(0, 0, 20'h01234, 0, "R9 ram byte");
    send(1, 2, 20'h5FFFF, 32'hDEADBEEF, "R9 ram top");
    send(0, 0, 20'hC0000, 0, "R1 rom base");
    send(0, 1, 20'hC7FFF, 0, "R1 rom limit");
    send(0, 0, 20'hC8000, 0, "R2 hole start");
    send(1, 2, 20'hCFFFF, 32'h11223344, "R2 hole end");
    send(0, 0, 20'hA0000, 0, "R3 video base");
    send(1, 1, 20'hBFFFF, 32'h0000ABCD, "R3 video top");
    set_emu(1);
    send(0, 0, 20'hA0010, 0, "R4 emu byte read");
    send(0, 1, 20'hB0000, 0, "R4 emu word read");
    send(0, 2, 20'hBFFFC, 0, "R4 emu dword read");
    send(1, 2, 20'hA0000, 32'hCAFEF00D, "R4 emu write dropped");
    send(0, 0, 20'hC0004, 0, "R4 emu rom unaffected");
    set_emu(0);
    for (int a = 32'hFFFF5; a <= 32'hFFFFF; a++)
      send(0, 0, 20'(a), 0, (a >= 32'hFFFFE) ? "R6 ident byte" : "R5 date byte");
    send(1, 0, 20'hFFFFE, 32'h55, "R5 ident write dropped");
    send(0, 2, 20'hFFFF5, 0, "R7 dword date");
    send(0, 2, 20'hFFFFD, 0, "R7 dword top cross");
    send(0, 1, 20'hFFFFE, 0, "R7 word model");
    send(0, 1, 20'hFFFFB, 0, "R7 word date tail");
    send_ld(20'hC3FFF, 0, 0, 20'hC4000, 0, "R10 same cycle old limit");
    send(0, 0, 20'hC4000, 0, "R10 new limit hole");
    send(0, 0, 20'hC3FFF, 0, "R10 new limit rom");
    drain();
    load_limit(20'hCFFFF);
    send(0, 0, 20'hC8000, 0, "R10 hole closed");
    drain();
    load_limit(20'h9FFFF);
    send(0, 0, 20'hA1234, 0, "R11 hole over video");
    send(0, 0, 20'hC0000, 0, "R11 hole over rom");
    set_emu(1);
    send(0, 0, 20'hA1234, 0, "R11 emu first");
    set_emu(0);
    drain();
    load_limit(20'hC7FFF);
    send(0, 0, 20'h60000, 0, "R8 overflow");
    send(0, 0, 20'h00100, 0, "R8 halt sticky");
    send(1, 2, 20'hD0000, 32'h0BADF00D, "R8 overflow above hole");
    drain();
    @(negedge clk);
    rst_n = 0; m_halt = 0; m_limit = LIM_RST;
    #1;
    check("R8 halt cleared by reset", 32'(halt), 32'h0);
    check("R12 resp_valid cleared", 32'(resp_valid), 32'h0);
    @(negedge clk);
    rst_n = 1;
    send(0, 1, 20'hC7FFF, 0, "R10 limit reset value");
    send(0, 0, 20'hC8000, 0, "R10 hole after reset");
    drain();
    repeat (2) @(negedge clk);
    check("R12 queue empty", 32'(sb_q.size()), 32'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule